// File: doc/BRIEF.md
# Data Transfer Watch Comparator Pair

This block watches operand transfers on a data bus and raises a flag when a transfer's data meets a programmed condition. It holds a set of identical comparators, two by default. Each has its own reference value and its own control inputs. Each comparator can test for equal, not equal, less than or greater than. A comparator can be limited to reads only or writes only. It can narrow the comparison to a word, a half-word or a byte, and can order values as signed or unsigned. A per-byte mask removes selected byte lanes from both sides of the comparison.

The control fields are plain input ports, held stable by the surrounding debug logic. The comparator looks at the transfer in the cycle where the transfer-valid strobe is high. It reports the result one clock later on a registered flag, one flag per comparator. Combining the flags and turning them into breakpoints is left to the logic downstream.

Top module: `data_watch_pair`

## Requirements
- R1: While bit 2 of a comparator's `rel_code` is 0, that comparator's `hit` stays 0. This includes codes 000 through 011.
- R2: With bit 2 of `rel_code` set, the low two bits choose the relation of transfer data to reference: 00 is equal, 01 is less than, 10 is greater than, 11 is not equal.
- R3: Bit 1 of `dir_qual` selects how access direction is handled. When it is 0, direction is ignored. Code 10 allows a match only on reads (`xfer_write`=0). Code 11 allows a match only on writes (`xfer_write`=1).
- R4: `op_size` 01 compares the full word. Code 10 compares only bits 15:0 of data and reference. Code 11 compares only bits 7:0. Code 00 makes the comparator inactive, so `hit` stays 0.
- R5: `signed_mode` 0 orders values as unsigned and 1 orders them as two's complement. In both cases the sign bit is the top bit of the selected size (bit 31, 15 or 7).
- R6: When bit i of `lane_mask` is 1, bits 8i+7:8i are forced to zero in both data and reference before the relation is evaluated. With all lanes masked, equal matches and not equal does not.
- R7: `hit` is registered. It shows the result for the transfer seen at the previous rising edge. It is 0 after a cycle with `xfer_valid` low. A synchronous `rst` clears it.
- R8: The comparators are independent. Each one's `hit` depends only on its own reference and control fields and on the shared transfer inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| xfer_valid | input | 1 | A transfer is present this cycle |
| xfer_write | input | 1 | 1 = write transfer, 0 = read transfer |
| xfer_data | input | DATA_W | Transfer operand |
| ref_val | input | NUM_UNITS x DATA_W | Reference value per comparator |
| rel_code | input | NUM_UNITS x 3 | Relation code per comparator |
| dir_qual | input | NUM_UNITS x 2 | Direction qualifier per comparator |
| op_size | input | NUM_UNITS x 2 | Operand size per comparator |
| signed_mode | input | NUM_UNITS | Signed ordering per comparator |
| lane_mask | input | NUM_UNITS x DATA_W/8 | Byte lane mask per comparator |
| hit | output | NUM_UNITS | Registered match flag per comparator |

## Verification
Byte masking and signed sizing can act on the same lane in the same cycle. This happens when the mask clears the lane that holds the sign bit of a half-word or byte operand, which changes both the magnitude and the sign of the value being compared. The bench provokes this with signed half-word and byte compares whose mask covers the sign lane. It also uses random masks, sizes and signedness against references that differ from the data in only a few bits. Each cycle it judges the registered flag of both comparators against a behavioural model. The model applies the mask first, then takes the size and sign using integer arithmetic.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
   localparam int unsigned LANE_W = 8;

   typedef enum logic [1:0] {
      SZ_RSVD = 2'b00,
      SZ_WORD = 2'b01,
      SZ_HALF = 2'b10,
      SZ_BYTE = 2'b11
   } dwp_size_e;

   typedef enum logic [1:0] {
      REL_EQ = 2'b00,
      REL_LT = 2'b01,
      REL_GT = 2'b10,
      REL_NE = 2'b11
   } dwp_rel_e;
endpackage

// File: rtl/dwp_operand_shape.sv
module dwp_operand_shape
   import dwp_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned LANES = DATA_W / LANE_W
) (
   input  logic [DATA_W-1:0] raw,
   input  logic [LANES-1:0]  lane_off,
   input  logic [1:0]        size_sel,
   input  logic              as_signed,
   output logic [DATA_W:0]   shaped
);
   logic [DATA_W-1:0] kept;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign kept[g*LANE_W +: LANE_W] = lane_off[g] ? '0 : raw[g*LANE_W +: LANE_W];
   end

   always_comb begin
      case (dwp_size_e'(size_sel))
         SZ_HALF: shaped = {{(DATA_W-15){as_signed & kept[15]}}, kept[15:0]};
         SZ_BYTE: shaped = {{(DATA_W-7){as_signed & kept[7]}}, kept[7:0]};
         default: shaped = {as_signed & kept[DATA_W-1], kept};
      endcase
   end
endmodule

// File: rtl/dwp_relation.sv
module dwp_relation
   import dwp_pkg::*;
#(
   parameter int unsigned W = 33
) (
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   input  logic [1:0]   rel_sel,
   output logic         holds
);
   logic is_lt, is_eq;

   always_comb begin
      is_lt = $signed(lhs) < $signed(rhs);
      is_eq = (lhs == rhs);
      case (dwp_rel_e'(rel_sel))
         REL_EQ:  holds = is_eq;
         REL_LT:  holds = is_lt;
         REL_GT:  holds = !is_lt && !is_eq;
         default: holds = !is_eq;
      endcase
   end
endmodule

// File: rtl/dwp_unit.sv
module dwp_unit
   import dwp_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned LANES = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              xfer_valid,
   input  logic              xfer_write,
   input  logic [DATA_W-1:0] xfer_data,
   input  logic [DATA_W-1:0] ref_val,
   input  logic [2:0]        rel_code,
   input  logic [1:0]        dir_qual,
   input  logic [1:0]        op_size,
   input  logic              signed_mode,
   input  logic [LANES-1:0]  lane_mask,
   output logic              hit
);
   logic [DATA_W:0] data_s, ref_s;
   logic rel_true, enabled, dir_ok, hit_d;

   dwp_operand_shape #(.DATA_W(DATA_W)) u_shape_data (
      .raw(xfer_data), .lane_off(lane_mask), .size_sel(op_size),
      .as_signed(signed_mode), .shaped(data_s));

   dwp_operand_shape #(.DATA_W(DATA_W)) u_shape_ref (
      .raw(ref_val), .lane_off(lane_mask), .size_sel(op_size),
      .as_signed(signed_mode), .shaped(ref_s));

   dwp_relation #(.W(DATA_W+1)) u_rel (
      .lhs(data_s), .rhs(ref_s), .rel_sel(rel_code[1:0]), .holds(rel_true));

   always_comb begin
      enabled = rel_code[2] && (dwp_size_e'(op_size) != SZ_RSVD);
      dir_ok  = !dir_qual[1] || (dir_qual[0] == xfer_write);
      hit_d   = xfer_valid && enabled && dir_ok && rel_true;
   end

   always_ff @(posedge clk) begin
      if (rst) hit <= 1'b0;
      else     hit <= hit_d;
   end

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
      !rel_code[2] |=> !hit); // R1
   AST_DIR_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
      (dir_qual == 2'b10 && xfer_write) |=> !hit); // R3
   AST_DIR_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
      (dir_qual == 2'b11 && !xfer_write) |=> !hit); // R3
   AST_RSVD_SIZE_QUIET: assert property (@(posedge clk) disable iff (rst)
      (op_size == 2'b00) |=> !hit); // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !xfer_valid |=> !hit); // R7
   AST_ALL_MASKED_EQ: assert property (@(posedge clk) disable iff (rst)
      (xfer_valid && &lane_mask && rel_code == 3'b100 && op_size != 2'b00 && !dir_qual[1])
      |=> hit); // R6
endmodule

// File: rtl/data_watch_pair.sv
module data_watch_pair
   import dwp_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_UNITS = 2,
   localparam int unsigned LANES    = DATA_W / LANE_W
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              xfer_valid,
   input  logic                              xfer_write,
   input  logic [DATA_W-1:0]                 xfer_data,
   input  logic [NUM_UNITS-1:0][DATA_W-1:0]  ref_val,
   input  logic [NUM_UNITS-1:0][2:0]         rel_code,
   input  logic [NUM_UNITS-1:0][1:0]         dir_qual,
   input  logic [NUM_UNITS-1:0][1:0]         op_size,
   input  logic [NUM_UNITS-1:0]              signed_mode,
   input  logic [NUM_UNITS-1:0][LANES-1:0]   lane_mask,
   output logic [NUM_UNITS-1:0]              hit
);
   if ((DATA_W % LANE_W) != 0 || DATA_W < 16) begin : g_bad_width
      $error("data_watch_pair: DATA_W must be a multiple of 8 and at least 16");
   end
   if (NUM_UNITS < 1) begin : g_bad_units
      $error("data_watch_pair: NUM_UNITS must be at least 1");
   end

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      dwp_unit #(.DATA_W(DATA_W)) u_cmp (
         .clk(clk), .rst(rst),
         .xfer_valid(xfer_valid), .xfer_write(xfer_write), .xfer_data(xfer_data),
         .ref_val(ref_val[u]), .rel_code(rel_code[u]), .dir_qual(dir_qual[u]),
         .op_size(op_size[u]), .signed_mode(signed_mode[u]),
         .lane_mask(lane_mask[u]), .hit(hit[u]));
   end

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (hit == '0)); // R7
endmodule

// File: tb/data_watch_pair_bench.sv
`timescale 1ns/1ps
module data_watch_pair_bench;
   logic clk = 1'b0;
   logic rst;
   logic xfer_valid, xfer_write;
   logic [31:0] xfer_data;
   logic [1:0][31:0] ref_val;
   logic [1:0][2:0] rel_code;
   logic [1:0][1:0] dir_qual, op_size;
   logic [1:0] signed_mode;
   logic [1:0][3:0] lane_mask;
   logic [1:0] hit;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   data_watch_pair u_data_watch_pair (
      .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_write(xfer_write),
      .xfer_data(xfer_data), .ref_val(ref_val), .rel_code(rel_code),
      .dir_qual(dir_qual), .op_size(op_size), .signed_mode(signed_mode),
      .lane_mask(lane_mask), .hit(hit));

   function automatic longint norm(logic [31:0] v, logic [3:0] mk, int w, bit sm);
      longint r = 0;
      for (int i = 0; i < 4; i++)
         if (!mk[i]) r = r | (longint'(v[8*i +: 8]) << (8*i));
      r = r & ((longint'(1) << w) - 1);
      if (sm && r[w-1]) r = r - (longint'(1) << w);
      return r;
   endfunction

   function automatic bit model(int u);
      longint a, b;
      int w;
      if (rst || !xfer_valid) return 0;
      if (!rel_code[u][2] || op_size[u] == 2'b00) return 0;
      if (dir_qual[u][1] && (dir_qual[u][0] != xfer_write)) return 0;
      w = (op_size[u] == 2'b01) ? 32 : (op_size[u] == 2'b10) ? 16 : 8;
      a = norm(xfer_data, lane_mask[u], w, signed_mode[u]);
      b = norm(ref_val[u], lane_mask[u], w, signed_mode[u]);
      case (rel_code[u][1:0])
         2'b00:   return a == b;
         2'b01:   return a < b;
         2'b10:   return a > b;
         default: return a != b;
      endcase
   endfunction

   task automatic cfg(int u, logic [31:0] r, logic [2:0] rc, logic [1:0] dq,
                      logic [1:0] sz, bit sm, logic [3:0] mk);
      ref_val[u] = r; rel_code[u] = rc; dir_qual[u] = dq;
      op_size[u] = sz; signed_mode[u] = sm; lane_mask[u] = mk;
   endtask

   // Called at a falling edge: drive, let one rising edge pass, compare at the next falling edge.
   task automatic cyc(string tag, bit v, bit w, logic [31:0] d);
      bit exp0, exp1;
      xfer_valid = v; xfer_write = w; xfer_data = d;
      @(posedge clk);
      exp0 = model(0);
      exp1 = model(1);
      @(negedge clk);
      checks += 2;
      if (hit[0] !== exp0) begin
         errors++;
         $display("FAIL %s unit 0 hit=%b expected=%b", tag, hit[0], exp0);
      end
      if (hit[1] !== exp1) begin
         errors++;
         $display("FAIL %s unit 1 hit=%b expected=%b", tag, hit[1], exp1);
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      cfg(0, 32'h1234_5678, 3'b100, 2'b00, 2'b01, 1'b0, 4'h0);
      cfg(1, 32'h0000_0010, 3'b101, 2'b00, 2'b01, 1'b0, 4'h0);
      @(negedge clk);
      cyc("R7 reset", 1, 0, 32'h1234_5678);
      rst = 1'b0;
      cyc("R2 equal and R8 independent", 1, 0, 32'h1234_5678);
      cyc("R7 idle", 0, 0, 32'h1234_5678);
      cfg(0, 32'h1234_5678, 3'b000, 2'b00, 2'b01, 1'b0, 4'h0);
      cyc("R1 off 000", 1, 0, 32'h1234_5678);
      cfg(0, 32'h1234_5678, 3'b011, 2'b00, 2'b01, 1'b0, 4'h0);
      cyc("R1 off 011", 1, 0, 32'h1234_5679);
      cfg(0, 32'h0000_0009, 3'b101, 2'b00, 2'b01, 1'b0, 4'h0);
      cyc("R2 less", 1, 0, 32'h0000_0005);
      cfg(0, 32'h0000_0009, 3'b110, 2'b00, 2'b01, 1'b0, 4'h0);
      cyc("R2 greater", 1, 1, 32'h8000_0000);
      cfg(0, 32'h0000_0009, 3'b111, 2'b00, 2'b01, 1'b0, 4'h0);
      cyc("R2 not equal", 1, 1, 32'h0000_0009);
      cfg(0, 32'hAAAA_0000, 3'b100, 2'b10, 2'b01, 1'b0, 4'h0);
      cyc("R3 read only, write", 1, 1, 32'hAAAA_0000);
      cyc("R3 read only, read", 1, 0, 32'hAAAA_0000);
      cfg(0, 32'hAAAA_0000, 3'b100, 2'b11, 2'b01, 1'b0, 4'h0);
      cyc("R3 write only, read", 1, 0, 32'hAAAA_0000);
      cyc("R3 write only, write", 1, 1, 32'hAAAA_0000);
      cfg(0, 32'hAAAA_0000, 3'b100, 2'b01, 2'b01, 1'b0, 4'h0);
      cyc("R3 ignore direction", 1, 1, 32'hAAAA_0000);
      cfg(0, 32'h5555_1234, 3'b100, 2'b00, 2'b00, 1'b0, 4'h0);
      cyc("R4 reserved size", 1, 0, 32'h5555_1234);
      cfg(0, 32'h5555_1234, 3'b100, 2'b00, 2'b10, 1'b0, 4'h0);
      cyc("R4 half ignores upper", 1, 0, 32'h9999_1234);
      cfg(0, 32'h5555_1234, 3'b100, 2'b00, 2'b11, 1'b0, 4'h0);
      cyc("R4 byte ignores upper", 1, 0, 32'h0000_AA34);
      cfg(0, 32'h0000_0001, 3'b101, 2'b00, 2'b11, 1'b1, 4'h0);
      cyc("R5 signed byte less", 1, 0, 32'h0000_0080);
      cfg(0, 32'h0000_0001, 3'b101, 2'b00, 2'b11, 1'b0, 4'h0);
      cyc("R5 unsigned byte not less", 1, 0, 32'h0000_0080);
      cfg(0, 32'h0000_0001, 3'b101, 2'b00, 2'b10, 1'b1, 4'h0);
      cyc("R5 signed half less", 1, 0, 32'h0000_8000);
      cfg(0, 32'h1111_2222, 3'b100, 2'b00, 2'b01, 1'b0, 4'hF);
      cyc("R6 all masked equal", 1, 0, 32'hDEAD_BEEF);
      cfg(0, 32'h1111_2222, 3'b111, 2'b00, 2'b01, 1'b0, 4'hF);
      cyc("R6 all masked not equal", 1, 0, 32'hDEAD_BEEF);
      cfg(0, 32'h1111_2200, 3'b100, 2'b00, 2'b01, 1'b0, 4'h1);
      cyc("R6 low lane masked", 1, 0, 32'h1111_22FF);
      cfg(0, 32'h0000_80FF, 3'b110, 2'b00, 2'b10, 1'b1, 4'h2);
      cfg(1, 32'h0000_0080, 3'b101, 2'b00, 2'b11, 1'b1, 4'h0);
      cyc("R5 R6 mask on sign lane", 1, 0, 32'h0000_0100);
      cyc("R5 R6 mask on sign lane b", 1, 0, 32'h0000_8001);
      for (int n = 0; n < 3000; n++) begin
         for (int u = 0; u < 2; u++) begin
            logic [31:0] r;
            r = $urandom;
            cfg(u, r, 3'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 4'($urandom));
         end
         begin
            logic [31:0] d;
            d = ($urandom % 2) ? ref_val[$urandom % 2] ^ (32'h1 << ($urandom % 32)) : $urandom;
            if ($urandom % 4 == 0) d = ref_val[0];
            rst = ($urandom % 97 == 0);
            cyc("R2 R8 random", 1'($urandom % 8 != 0), 1'($urandom), d);
         end
      end
      rst = 1'b0;
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule